// File: doc/BRIEF.md
# Coupling-Aware Bus-Invert Encoder

This block sits at the sending end of a narrow on-chip data bus made of tightly packed parallel wires. For each incoming word it chooses whether to put the word on the wires as it is or with every bit flipped. The aim is to lower the charge moved through the capacitance between neighbouring wires. The block compares the candidate word with the value now held on the bus. Each neighbouring wire pair is rated with a two-bit code, and switching in opposite directions counts double. A majority vote over all the code bits then makes the flip decision.

The receiver must know which words arrived flipped, but the scheme adds no wire for that. Words are grouped into bursts of eight. After the eighth word of a burst, the block drives one extra bus cycle whose bits are the eight flip decisions, and it raises a marker output during that cycle. Input uses a valid/ready handshake. The bus itself is one register bank launched on a single clock edge, so every wire in a cycle switches at the same moment.

Top module: `xt_coupling_inv_tx`

## Requirements
- R1: During and right after a synchronous active-high reset, bus_out is all zeros, frame_flag is low and in_ready is high. A reset in the middle of a burst starts a new burst of eight.
- R2: Each adjacent wire pair (bit i, bit i+1) gets a 2-bit code from the change between the current bus value and the candidate word. The code is 01 when exactly one of the two wires changes. It is 11 when both change in opposite directions, which happens when the two old bits differ. It is 00 when neither wire changes or both change the same way.
- R3: The 14 code bits and one input tied to 0 form a 15-input majority vote. When 8 or more code bits are 1, the word is driven inverted (bus_out = ~in_data). Otherwise it is driven unchanged.
- R4: The value compared against is the value last driven on bus_out. This holds whether that value was an inverted word or a flag cycle.
- R5: A word accepted on a rising edge (in_valid and in_ready both high) appears on bus_out right after that edge, and frame_flag is low in that cycle.
- R6: After every eighth accepted word, the next cycle is a flag cycle: frame_flag is high and bit k of bus_out is the inversion decision of word k of the burst (word 0 in bit 0, 1 = inverted).
- R7: in_ready is low while the flag cycle is being produced. A word offered then is not taken and has no effect on the bus or on the burst.
- R8: When no word is accepted and no flag cycle is due, bus_out keeps its value and frame_flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all bus wires launch on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A candidate word is offered |
| in_data | input | 8 | Candidate word |
| in_ready | output | 1 | Low while the flag cycle is being produced |
| bus_out | output | 8 | Registered value driven onto the bus wires |
| frame_flag | output | 1 | High in the cycle whose bus_out carries the inversion flags |

## Verification
Each data result is due on bus_out at the first rising edge after the word is taken, since exactly one register lies on the path. The flag cycle's contents and frame_flag follow one edge after the eighth word. The bench applies inputs and reads outputs on falling edges. It records in_ready just before the edge that may take a word, and reads bus_out and frame_flag half a cycle after that edge, so each check falls in the single cycle where its result first becomes visible. Expected values come from a reference model in the bench that sums weighted pair costs. A hand-worked table also covers the vote at exactly 7 and exactly 8.

// File: rtl/xt_pkg.sv
package xt_pkg;

    // Coupling code for one adjacent wire pair
    typedef enum logic [1:0] {
        PC_QUIET   = 2'b00,  // no switching, or both in the same direction
        PC_SINGLE  = 2'b01,  // exactly one wire switches
        PC_OPPOSED = 2'b11   // both switch, in opposite directions
    } pair_code_t;

    // Sequencer phase
    typedef enum logic {
        PH_DATA  = 1'b0,
        PH_FLAGS = 1'b1
    } phase_t;

    // Rate the move of two neighbouring wires from (pa,pb) to (na,nb)
    function automatic pair_code_t classify_pair(input logic pa, input logic pb,
                                                 input logic na, input logic nb);
        logic ta;
        logic tb;
        ta = pa ^ na;
        tb = pb ^ nb;
        if (ta ^ tb)
            return PC_SINGLE;
        else if (ta && tb && (pa != pb))
            return PC_OPPOSED;
        else
            return PC_QUIET;
    endfunction

endpackage

// File: rtl/xt_pair_classifier.sv
module xt_pair_classifier #(
    parameter int W = 8,
    localparam int NCODE = 2 * (W - 1)
) (
    input  logic [W-1:0]     prev,
    input  logic [W-1:0]     cand,
    output logic [NCODE-1:0] code_bits
);
    import xt_pkg::*;

    for (genvar p = 0; p < W - 1; p++) begin : g_pair
        pair_code_t code;
        assign code = classify_pair(prev[p], prev[p+1], cand[p], cand[p+1]);
        assign code_bits[2*p +: 2] = code;
    end

endmodule

// File: rtl/xt_majority.sv
module xt_majority #(
    parameter int N  = 15,
    parameter int TH = 8,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0] votes,
    output logic         hit
);
    logic [CW-1:0] tally;

    always_comb begin
        tally = '0;
        for (int i = 0; i < N; i++)
            tally = tally + CW'(votes[i]);
    end

    assign hit = (tally >= CW'(TH));

endmodule

// File: rtl/xt_burst_seq.sv
module xt_burst_seq #(
    parameter int BURST = 8,
    localparam int SW = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             inv,
    output logic             flag_phase,
    output logic [BURST-1:0] flags
);
    import xt_pkg::*;

    localparam logic [SW-1:0] LAST = SW'(BURST - 1);

    phase_t           state_q;
    logic [SW-1:0]    slot_q;
    logic [BURST-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_DATA;
            slot_q  <= '0;
            flags_q <= '0;
        end else begin
            case (state_q)
                PH_DATA: begin
                    if (accept) begin
                        flags_q[slot_q] <= inv;
                        if (slot_q == LAST) begin
                            slot_q  <= '0;
                            state_q <= PH_FLAGS;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                default: state_q <= PH_DATA;
            endcase
        end
    end

    assign flag_phase = (state_q == PH_FLAGS);
    assign flags      = flags_q;

    // R6: the flag cycle lasts exactly one cycle
    a_r6_one_flag_beat: assert property (@(posedge clk) disable iff (rst)
        state_q == PH_FLAGS |=> state_q == PH_DATA);

    // R7: the edge logic never takes a word during the flag cycle
    a_r7_no_accept_in_flags: assert property (@(posedge clk) disable iff (rst)
        state_q == PH_FLAGS |-> !accept);

endmodule

// File: rtl/xt_coupling_inv_tx.sv
module xt_coupling_inv_tx #(
    parameter int W     = 8,
    parameter int BURST = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic [W-1:0] bus_out,
    output logic         frame_flag
);
    localparam int NPAIR  = W - 1;
    localparam int NCODE  = 2 * NPAIR;
    localparam int NVOTE  = NCODE + 1;
    localparam int THRESH = (NVOTE + 1) / 2;

    logic [W-1:0]     bus_q;
    logic             frame_q;
    logic [NCODE-1:0] code_bits;
    logic             vote_hit;
    logic             flag_phase;
    logic [BURST-1:0] flags;
    logic [W-1:0]     flag_word;
    logic             accept;

    xt_pair_classifier #(.W(W)) u_pairs (
        .prev      (bus_q),
        .cand      (in_data),
        .code_bits (code_bits)
    );

    // spare voter input tied low
    xt_majority #(.N(NVOTE), .TH(THRESH)) u_vote (
        .votes ({1'b0, code_bits}),
        .hit   (vote_hit)
    );

    xt_burst_seq #(.BURST(BURST)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .inv        (vote_hit),
        .flag_phase (flag_phase),
        .flags      (flags)
    );

    assign in_ready = !flag_phase;
    assign accept   = in_valid && in_ready;

    always_comb begin
        flag_word = '0;
        flag_word[BURST-1:0] = flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q   <= '0;
            frame_q <= 1'b0;
        end else if (flag_phase) begin
            bus_q   <= flag_word;
            frame_q <= 1'b1;
        end else begin
            frame_q <= 1'b0;
            if (accept)
                bus_q <= vote_hit ? ~in_data : in_data;
        end
    end

    assign bus_out    = bus_q;
    assign frame_flag = frame_q;

    // R3: a word that wins the vote goes out flipped
    a_r3_inverted_word: assert property (@(posedge clk) disable iff (rst)
        accept && vote_hit |=> bus_out == ~$past(in_data) && !frame_flag);

    // R3 and R5: a word that loses the vote goes out unchanged
    a_r3_plain_word: assert property (@(posedge clk) disable iff (rst)
        accept && !vote_hit |=> bus_out == $past(in_data) && !frame_flag);

    // R6: the flag cycle puts the collected decisions on the wires
    a_r6_flag_beat: assert property (@(posedge clk) disable iff (rst)
        flag_phase |=> frame_flag && bus_out == $past(flag_word));

    // R7: input is open again once the flag cycle is on the bus
    a_r7_ready_after_flags: assert property (@(posedge clk) disable iff (rst)
        frame_flag |-> in_ready);

    // R8: without a transfer the bus holds
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !accept && !flag_phase |=> $stable(bus_out) && !frame_flag);

endmodule

// File: tb/sim_xt_coupling_inv_tx.sv
module sim_xt_coupling_inv_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic [7:0] bus_out;
    logic       frame_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    logic [7:0] m_bus;
    logic [7:0] m_flags;
    int         m_slot;
    bit         m_pending;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    xt_coupling_inv_tx u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .bus_out    (bus_out),
        .frame_flag (frame_flag)
    );

    // {flag cycle, offered word, expected bus_out}
    localparam logic [16:0] VEC [0:17] = '{
        {1'b0, 8'h55, 8'h55}, {1'b0, 8'hAA, 8'h55}, {1'b0, 8'h00, 8'h00},
        {1'b0, 8'hFF, 8'hFF}, {1'b0, 8'h0F, 8'h0F}, {1'b0, 8'hF0, 8'hF0},
        {1'b0, 8'h33, 8'h33}, {1'b0, 8'hCC, 8'hCC}, {1'b1, 8'hFF, 8'h02},
        {1'b0, 8'hFD, 8'hFD}, {1'b0, 8'h55, 8'h55}, {1'b0, 8'h5A, 8'h5A},
        {1'b0, 8'hD5, 8'h2A}, {1'b0, 8'h2A, 8'h2A}, {1'b0, 8'hD5, 8'h2A},
        {1'b0, 8'h00, 8'h00}, {1'b0, 8'h80, 8'h80}, {1'b1, 8'hFF, 8'h28}
    };

    task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // weighted pair cost: one wire switching = 1, opposite switching = 2
    function automatic bit model_inv(input logic [7:0] prev, input logic [7:0] cand);
        int cost = 0;
        for (int i = 0; i < 7; i++) begin
            bit da = prev[i] ^ cand[i];
            bit db = prev[i+1] ^ cand[i+1];
            if (da != db) cost += 1;
            else if (da && db && (prev[i] != prev[i+1])) cost += 2;
        end
        return cost >= 8;
    endfunction

    function automatic void model_reset();
        m_bus = '0; m_flags = '0; m_slot = 0; m_pending = 1'b0;
    endfunction

    // called on a falling edge; returns on the next falling edge
    task automatic step(input bit v, input logic [7:0] d);
        bit was_flag;
        bit took;
        chk(in_ready == !m_pending, "R7 in_ready", {7'b0, in_ready}, {7'b0, !m_pending});
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        was_flag = m_pending;
        took = 1'b0;
        if (m_pending) begin
            m_bus = m_flags;
            m_pending = 1'b0;
        end else if (v) begin
            bit inv = model_inv(m_bus, d);
            took = 1'b1;
            m_bus = inv ? ~d : d;
            m_flags[m_slot] = inv;
            if (m_slot == 7) begin m_slot = 0; m_pending = 1'b1; end
            else m_slot++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (was_flag) begin
            chk(bus_out == m_bus, "R6 flag word", bus_out, m_bus);
            chk(frame_flag == 1'b1, "R6 frame_flag", {7'b0, frame_flag}, 8'h01);
        end else if (took) begin
            chk(bus_out == m_bus, "R3 R4 data word", bus_out, m_bus);
            chk(frame_flag == 1'b0, "R5 frame_flag", {7'b0, frame_flag}, 8'h00);
        end else begin
            chk(bus_out == m_bus, "R8 idle hold", bus_out, m_bus);
            chk(frame_flag == 1'b0, "R8 frame_flag", {7'b0, frame_flag}, 8'h00);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(bus_out == 8'h00, "R1 bus_out", bus_out, 8'h00);
        chk(frame_flag == 1'b0, "R1 frame_flag", {7'b0, frame_flag}, 8'h00);
        chk(in_ready == 1'b1, "R1 in_ready", {7'b0, in_ready}, 8'h01);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // table walk: pair codes (R2), vote at 7 and 8 (R3), reference (R4)
        for (int i = 0; i < 18; i++) begin
            step(1'b1, VEC[i][15:8]);
            chk(bus_out == VEC[i][7:0], "R2 R3 R4 table", bus_out, VEC[i][7:0]);
        end

        // R8: idle cycles between words
        step(1'b0, 8'h3C);
        step(1'b0, 8'hC3);

        // R1: reset after three words restarts the burst count
        step(1'b1, 8'h12);
        step(1'b1, 8'hED);
        step(1'b1, 8'h6B);
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b1, 8'(8'h11 * i + 8'h07));
        chk(m_pending == 1'b1, "R1 burst restart", 8'h00, 8'h00);
        step(1'b1, 8'hA5);   // flag cycle; offered word must be ignored (R7)

        // mixed stream with gaps
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3] | lfsr[9], lfsr[11:4]);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule